// File: doc/BRIEF.md
# Interval-Table Pulse Pattern Generator

This block produces a repeating digital waveform whose high and low phases come from a small table of interval lengths. A 16-bit timebase counter runs without being cleared and advances only on tick cycles. The ticks come from a prescaler that divides a base enable input. A compare register holds the count at which the next output edge occurs. When the counter reaches that value, the pin is set or cleared according to the current output mode. The mode then flips, and the compare register moves forward by the next table interval, added modulo 2^16. Because of this, a waveform can run for longer than one counter lap and still keep exact phase lengths.

A one-cycle start strobe arms the block. It loads the counter with all ones and the compare register with zero, so the first rising edge falls on the first tick after the start. The table index and a one-cycle wrap marker are available on outputs. Other logic can use them to line up its own activity with the start of each pattern period. Table entries alternate: entry 0 is a high phase, entry 1 a low phase, and so on.

Top module: `pulse_pattern_gen`

## Requirements
- R1: While running, the timebase advances exactly once per DIV cycles in which `en_i` is high. Cycles with `en_i` low do not count toward this.
- R2: The timebase counter is CW bits wide and free-running. It goes from all ones to zero on a tick and is never cleared by a compare match.
- R3: A high on `start_i` loads the counter with all ones, the compare register with zero, the index with 0 and set mode, and clears `pulse_o`. `pulse_o` then goes high in the cycle after the first tick, so with DIV=1 it rises one cycle after the start cycle.
- R4: On a match, the new compare value equals the incremented count plus the table entry at the current index, taken modulo 2^CW.
- R5: A match in set mode drives `pulse_o` to 1. A match in reset mode drives it to 0. After every match the mode toggles between the two.
- R6: After the first rising edge, each high or low phase lasts exactly table entry k ticks. Entry 0 is a high phase, and k advances by one per phase and cycles through the table.
- R7: `edge_idx_o` advances by one on each match and returns to 0 after entry N-1.
- R8: `wrap_o` is high for exactly the one cycle in which `edge_idx_o` has just returned to 0 from N-1, and low at all other times.
- R9: After reset and until the first start, `pulse_o`, `edge_idx_o` and `wrap_o` stay at 0 whatever `en_i` does.
- R10: `pulse_o` and `edge_idx_o` change only in the cycle after a match or a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Base enable that the prescaler divides down to timebase ticks |
| start_i | input | 1 | One-cycle strobe that arms or re-arms the pattern from its first edge |
| pulse_o | output | 1 | Generated pulse waveform |
| edge_idx_o | output | IDXW (2 by default) | Index of the table entry that schedules the next edge |
| wrap_o | output | 1 | One-cycle marker when the index returns to 0 |

## Verification
The assertions assume three things. Every table entry is at least one tick, because a zero entry would push the next edge a whole counter lap away. `start_i` and `en_i` are synchronous to `clk`. Restarts may arrive at any time, including in the same cycle as a match. The bench tables contain only non-zero entries. One instance holds its enable high for more than two full periods, so the counter wraps during the second period. A second instance runs with a divided prescaler and a pseudo-random enable, and it is restarted in the middle of a pattern.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    // Output action applied on the next compare match
    typedef enum logic {
        MODE_SET = 1'b0,
        MODE_CLR = 1'b1
    } out_mode_e;

    localparam int unsigned PPG_CNT_W = 16;

    // Width needed to index a table of n entries (at least one bit)
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ppg_prescaler.sv
module ppg_prescaler #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        tick_o = 1'b0;
        if (clear_i) begin
            s_d.cnt = '0;
        end else if (run_i && en_i) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt = '0;
                tick_o  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/ppg_timebase.sv
module ppg_timebase #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          tick_i,
    input  logic [CW-1:0] interval_i,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] cmp_o,
    output logic          match_o
);
    typedef struct packed {
        logic [CW-1:0] count;
        logic [CW-1:0] cmp;
    } tb_state_t;

    tb_state_t     s_d, s_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        s_d     = s_q;
        match_o = 1'b0;
        cnt_inc = s_q.count + 1'b1;
        if (load_i) begin
            // all ones so the first tick lands on compare value zero
            s_d.count = '1;
            s_d.cmp   = '0;
        end else if (tick_i) begin
            s_d.count = cnt_inc;
            if (cnt_inc == s_q.cmp) begin
                match_o = 1'b1;
                s_d.cmp = cnt_inc + interval_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.count;
    assign cmp_o   = s_q.cmp;

endmodule

// File: rtl/ppg_sequencer.sv
module ppg_sequencer
    import ppg_pkg::*;
#(
    parameter int unsigned       N         = 4,
    parameter int unsigned       CW        = 16,
    parameter logic [N*CW-1:0]   INTERVALS = {16'd46874, 16'd4688, 16'd6250, 16'd4688},
    localparam int unsigned      IDXW      = idx_width(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            match_i,
    output logic [CW-1:0]   interval_o,
    output logic            pulse_o,
    output logic [IDXW-1:0] idx_o,
    output logic            wrap_o
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N - 1);

    typedef struct packed {
        logic [IDXW-1:0] idx;
        out_mode_e       mode;
        logic            pulse;
        logic            wrap;
    } seq_state_t;

    seq_state_t    s_d, s_q;
    logic [CW-1:0] tbl [N];

    // unpack the interval table, entry 0 in the low bits
    for (genvar g = 0; g < N; g++) begin : g_tbl
        assign tbl[g] = INTERVALS[g*CW +: CW];
    end

    always_comb begin
        s_d      = s_q;
        s_d.wrap = 1'b0;
        if (load_i) begin
            s_d.idx   = '0;
            s_d.mode  = MODE_SET;
            s_d.pulse = 1'b0;
        end else if (match_i) begin
            s_d.pulse = (s_q.mode == MODE_SET);
            s_d.mode  = (s_q.mode == MODE_SET) ? MODE_CLR : MODE_SET;
            if (s_q.idx == LAST_IDX) begin
                s_d.idx  = '0;
                s_d.wrap = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign interval_o = tbl[s_q.idx];
    assign pulse_o    = s_q.pulse;
    assign idx_o      = s_q.idx;
    assign wrap_o     = s_q.wrap;

endmodule

// File: rtl/pulse_pattern_gen.sv
module pulse_pattern_gen
    import ppg_pkg::*;
#(
    parameter int unsigned     CW        = PPG_CNT_W,
    parameter int unsigned     N         = 4,
    parameter int unsigned     DIV       = 8,
    parameter logic [N*CW-1:0] INTERVALS = {16'd46874, 16'd4688, 16'd6250, 16'd4688},
    localparam int unsigned    IDXW      = idx_width(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            start_i,
    output logic            pulse_o,
    output logic [IDXW-1:0] edge_idx_o,
    output logic            wrap_o
);
    typedef struct packed {
        logic running;
    } top_state_t;

    top_state_t    s_d, s_q;
    logic          running_q;
    logic          tick_w;
    logic          match_w;
    logic [CW-1:0] count_w;
    logic [CW-1:0] cmp_w;
    logic [CW-1:0] interval_w;

    always_comb begin
        s_d         = s_q;
        s_d.running = s_q.running | start_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign running_q = s_q.running;

    ppg_prescaler #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .run_i   (running_q),
        .en_i    (en_i),
        .tick_o  (tick_w)
    );

    ppg_timebase #(.CW(CW)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_i),
        .tick_i     (tick_w),
        .interval_i (interval_w),
        .count_o    (count_w),
        .cmp_o      (cmp_w),
        .match_o    (match_w)
    );

    ppg_sequencer #(.N(N), .CW(CW), .INTERVALS(INTERVALS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_i),
        .match_i    (match_w),
        .interval_o (interval_w),
        .pulse_o    (pulse_o),
        .idx_o      (edge_idx_o),
        .wrap_o     (wrap_o)
    );

endmodule

// File: rtl/ppg_checker.sv
module ppg_checker #(
    parameter int unsigned CW   = 16,
    parameter int unsigned N    = 4,
    parameter int unsigned DIV  = 8,
    parameter int unsigned IDXW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            en_i,
    input logic            running,
    input logic            tick,
    input logic            match,
    input logic [CW-1:0]   count,
    input logic [CW-1:0]   cmp,
    input logic [CW-1:0]   interval,
    input logic [IDXW-1:0] idx,
    input logic            pulse,
    input logic            wrap
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N - 1);

    // enable cycles seen since the last tick, for the prescaler window
    int en_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 en_seen <= 0;
        else if (start_i || tick)   en_seen <= 0;
        else if (running && en_i)   en_seen <= en_seen + 1;
    end

    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (en_i && en_seen == int'(DIV) - 1));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !start_i) |=> count == CW'($past(count) + 1'b1));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start_i) |=> $stable(count));

    assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (count == '1 && cmp == '0 && idx == '0 && !pulse && !wrap));

    assert_next_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !start_i) |=> cmp == CW'($past(count) + $past(interval) + 1'b1));

    assert_set_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !start_i && !pulse) |=> pulse);

    assert_clear_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !start_i && pulse) |=> !pulse);

    assert_idx_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !start_i && idx == LAST_IDX) |=> (idx == '0 && wrap));

    assert_idx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !start_i && idx != LAST_IDX) |=> idx == IDXW'($past(idx) + 1'b1));

    assert_wrap_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!match || start_i) |=> !wrap);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!pulse && !wrap && !tick && idx == '0));

    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && !start_i) |=> ($stable(pulse) && $stable(idx)));

endmodule

bind pulse_pattern_gen ppg_checker #(
    .CW   (CW),
    .N    (N),
    .DIV  (DIV),
    .IDXW (IDXW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .en_i     (en_i),
    .running  (running_q),
    .tick     (tick_w),
    .match    (match_w),
    .count    (count_w),
    .cmp      (cmp_w),
    .interval (interval_w),
    .idx      (edge_idx_o),
    .pulse    (pulse_o),
    .wrap     (wrap_o)
);

// File: tb/pulse_pattern_gen_tb.sv
module pulse_pattern_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 126500;
    localparam int WATCHDOG   = 190000;
    localparam int DIV0       = 1;
    localparam int DIV1       = 3;
    localparam logic [63:0] TBL1_PACKED = {16'd7, 16'd2, 16'd5, 16'd3};

    typedef struct {
        longint tk;
        longint nxt;
        int     enc;
        int     ix;
        bit     lvl;
        bit     wr;
        bit     run;
    } mdl_t;

    int tbl0 [4] = '{4688, 6250, 4688, 46874};
    int tbl1 [4] = '{3, 5, 2, 7};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st0 = 1'b0, st1 = 1'b0, en0 = 1'b0, en1 = 1'b0;
    logic p0, p1, w0, w1;
    logic [1:0] i0, i1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    longint pcyc = 0;
    mdl_t m0, m1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_pattern_gen #(.DIV(DIV0)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en0), .start_i(st0),
        .pulse_o(p0), .edge_idx_o(i0), .wrap_o(w0)
    );

    pulse_pattern_gen #(.DIV(DIV1), .INTERVALS(TBL1_PACKED)) u_dut_div (
        .clk(clk), .rst_n(rst_n), .en_i(en1), .start_i(st1),
        .pulse_o(p1), .edge_idx_o(i1), .wrap_o(w1)
    );

    task automatic mdl_clear(inout mdl_t m);
        m.tk = 0; m.nxt = 1; m.enc = 0; m.ix = 0;
        m.lvl = 1'b0; m.wr = 1'b0; m.run = 1'b0;
    endtask

    // behavioural reference: absolute tick numbers, no wrapping counter
    task automatic mdl_step(inout mdl_t m, input bit s, input bit e,
                            input int div, input int tb [4]);
        if (s) begin
            mdl_clear(m);
            m.run = 1'b1;
        end else begin
            m.wr = 1'b0;
            if (m.run && e) begin
                m.enc++;
                if (m.enc == div) begin
                    m.enc = 0;
                    m.tk++;
                    if (m.tk == m.nxt) begin
                        m.lvl = !m.lvl;
                        m.nxt = m.tk + tb[m.ix];
                        if (m.ix == 3) begin
                            m.ix = 0;
                            m.wr = 1'b1;
                        end else begin
                            m.ix++;
                        end
                    end
                end
            end
        end
    endtask

    task automatic check_bit(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, pcyc);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // reference model advances on the same edge as the design
    longint start_pc = -1;
    always @(posedge clk) begin
        pcyc++;
        if (!rst_n) begin
            mdl_clear(m0);
            mdl_clear(m1);
        end else begin
            if (st0) start_pc = pcyc;
            mdl_step(m0, st0, en0, DIV0, tbl0);
            mdl_step(m1, st1, en1, DIV1, tbl1);
        end
    end

    // cycle-by-cycle comparison and phase-length measurement
    bit     prev_p0 = 1'b0;
    bit     seen_edge = 1'b0;
    bit     first_rise_checked = 1'b0;
    longint last_pc = 0;
    int     nphase = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!m0.run) begin
                // R9: idle outputs before the first start
                check_bit("R9 inst0 idle pulse", p0, 0);
                check_bit("R9 inst0 idle idx", i0, 0);
                check_bit("R9 inst0 idle wrap", w0, 0);
            end else begin
                check_bit("R5/R10 inst0 pulse", p0, m0.lvl);
                check_bit("R7/R10 inst0 idx", i0, m0.ix);
                check_bit("R8 inst0 wrap", w0, m0.wr);
            end
            check_bit("R1/R5 inst1 pulse", p1, m1.lvl);
            check_bit("R7/R10 inst1 idx", i1, m1.ix);
            check_bit("R8 inst1 wrap", w1, m1.wr);

            if (p0 != prev_p0) begin
                if (!first_rise_checked) begin
                    first_rise_checked = 1'b1;
                    // R3: first rising edge one cycle after the start is loaded
                    check_bit("R3 first rise delay", pcyc - start_pc, 1);
                end
                if (seen_edge) begin
                    check_bit("R4/R6 phase length", pcyc - last_pc, tbl0[nphase % 4]);
                    nphase++;
                end
                seen_edge = 1'b1;
                last_pc = pcyc;
                prev_p0 = p0;
            end
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // enable activity before any start must have no effect (R9)
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            en0 = k[0];
            en1 = ~k[0];
        end
        @(negedge clk);
        en0 = 1'b1;
        st0 = 1'b1;
        st1 = 1'b1;
        @(negedge clk);
        st0 = 1'b0;
        st1 = 1'b0;
        for (int k = 0; k < RUN_CYCLES; k++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            en1 = lfsr[0] | lfsr[3];
            // restart the divided instance mid-pattern
            st1 = (k == 40000) || (k == 40017);
        end
        st1 = 1'b0;
        @(negedge clk);
        // R2: two full periods observed, spanning a counter wrap
        check_bit("R2 phases across wrap", (nphase >= 8) ? 1 : 0, 1);
        check_bit("R2 ticks beyond one lap", (m0.tk > 65536) ? 1 : 0, 1);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, RUN_CYCLES);
            finish_run();
        end
    end

endmodule